// File: doc/BRIEF.md
# Sampling phase synchronization controller

This block turns an asynchronous rising edge on a sync input into a single-cycle, retimed pulse in the system clock domain. The pulse leaves the block on `msync_o`, where external modulators use it to align their analog sampling phase. Inside the block, the same pulse restarts a decimation phase counter. That counter marks convolution cycles and raises a one-cycle word-valid strobe at each output word boundary.

When selected, the pulse also rewinds the read pointer of a small built-in test pattern generator. The pointer steps through a parameterized bit pattern once per modulator bit-clock enable. Two enable bits gate the behaviour. One gates pulse generation as a whole. The other gates the pointer restart.

A sync edge that lands exactly on the counter's natural wrap leaves the counter unchanged. Periodic sync at the output word rate is therefore seamless.

Top module: `phase_sync_ctrl`

## Requirements
- R1: While `rst_ni` is low: `msync_o` is 0, `word_valid_o` is 0, `phase_o` equals DECIM-1, `test_ptr_o` is 0 and `test_bit_o` is 0.
- R2: Let `sync_i` go from 0 to 1 before clock edge E1, with `msync_en_i` high. Then `msync_o` is high only in the cycle that follows edge E3, which gives a fixed latency of three edges and a one-cycle width.
- R3: Holding `sync_i` high, or a falling edge on `sync_i`, produces no `msync_o` pulse.
- R4: With `msync_en_i` low, a rising edge on `sync_i` produces no pulse, and the phase counter and the pattern pointer keep their free-running course.
- R5: Without sync, `phase_o` counts down from DECIM-1 to 0 and then reloads DECIM-1. `word_valid_o` is high in exactly the cycles where `phase_o` is 0, so it occurs once every DECIM cycles.
- R6: In the cycle after `msync_o` is high, `phase_o` equals DECIM-1. The next `word_valid_o` comes DECIM cycles after the `msync_o` cycle.
- R7: If `msync_o` falls in a cycle where `phase_o` is 0, the word-valid cadence is unchanged. Sync edges spaced exactly DECIM cycles apart keep the strobe every DECIM cycles.
- R8: With `test_en_i` high, `test_ptr_o` increments on each cycle where `mod_bclk_en_i` is high, holds otherwise, and wraps from PAT_LEN-1 to 0. `test_bit_o` is bit `test_ptr_o` of PATTERN, with bit 0 as the first point.
- R9: With `test_en_i` and `tsync_en_i` high, `test_ptr_o` is 0 in the cycle after `msync_o`. This restart takes priority over a bit-clock advance in the same cycle.
- R10: With `tsync_en_i` low, `msync_o` does not disturb `test_ptr_o`, which keeps advancing.
- R11: With `test_en_i` low, `test_bit_o` is 0. From the next edge on, `test_ptr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Asynchronous sync request, rising-edge sensitive |
| msync_en_i | input | 1 | Enables pulse generation |
| tsync_en_i | input | 1 | Lets the pulse restart the pattern pointer |
| test_en_i | input | 1 | Enables the test pattern generator |
| mod_bclk_en_i | input | 1 | Modulator bit-clock enable, advances the pointer |
| msync_o | output | 1 | Retimed one-cycle sync pulse |
| word_valid_o | output | 1 | Output word boundary strobe |
| phase_o | output | $clog2(DECIM) | Decimation phase counter |
| test_ptr_o | output | $clog2(PAT_LEN) | Pattern read pointer |
| test_bit_o | output | 1 | Current test pattern bit |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a sync pulse and the counter's natural wrap. The bench times the edge from the observed phase so that the pulse meets phase 0, repeats the edge every DECIM cycles, and expects an undisturbed strobe each time. The second pair is a pulse and a bit-clock advance. The bench keeps `mod_bclk_en_i` high throughout a restart and expects the pointer to read 0 and then 1, not a value advanced from the old position.

// File: rtl/phase_sync_pkg.sv
package phase_sync_pkg;
  localparam int unsigned DEF_DECIM   = 8;
  localparam int unsigned DEF_PAT_LEN = 16;
  localparam int unsigned DEF_STAGES  = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/psc_sync_edge.sv
module psc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic en_i,
  output logic pulse_o
);
  // chain[STAGES-1] is the last synchronizer flop, chain[STAGES] its delayed copy
  logic [STAGES:0] chain_q;
  logic            rise;
  logic            pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], sync_i};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= rise & en_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/psc_phase_cnt.sv
module psc_phase_cnt #(
  parameter int unsigned DECIM = 8,
  localparam int unsigned CNT_W = phase_sync_pkg::idx_w(DECIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_wrap;

  assign at_wrap = (cnt_q == '0);

  // restart and natural wrap load the same value: sync on the wrap is seamless
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= TOP;
    else if (restart_i || at_wrap) cnt_q <= TOP;
    else                         cnt_q <= cnt_q - CNT_W'(1);
  end

  assign phase_o = cnt_q;
  assign valid_o = at_wrap & rst_ni;
endmodule

// File: rtl/psc_pattern_gen.sv
module psc_pattern_gen #(
  parameter int unsigned         PAT_LEN = 16,
  parameter logic [PAT_LEN-1:0]  PATTERN = 16'hB4E1,
  localparam int unsigned        PTR_W   = phase_sync_pkg::idx_w(PAT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_i,
  input  logic             restart_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             bit_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PAT_LEN - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (!en_i)     ptr_q <= '0;
    else if (restart_i) ptr_q <= '0;
    else if (adv_i)     ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;
  assign bit_o = en_i & rst_ni & PATTERN[ptr_q];
endmodule

// File: rtl/phase_sync_ctrl.sv
module phase_sync_ctrl #(
  parameter int unsigned        DECIM   = phase_sync_pkg::DEF_DECIM,
  parameter int unsigned        PAT_LEN = phase_sync_pkg::DEF_PAT_LEN,
  parameter logic [PAT_LEN-1:0] PATTERN = 16'hB4E1,
  parameter int unsigned        STAGES  = phase_sync_pkg::DEF_STAGES,
  localparam int unsigned       CNT_W   = phase_sync_pkg::idx_w(DECIM),
  localparam int unsigned       PTR_W   = phase_sync_pkg::idx_w(PAT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             msync_en_i,
  input  logic             tsync_en_i,
  input  logic             test_en_i,
  input  logic             mod_bclk_en_i,
  output logic             msync_o,
  output logic             word_valid_o,
  output logic [CNT_W-1:0] phase_o,
  output logic [PTR_W-1:0] test_ptr_o,
  output logic             test_bit_o
);
  logic msync;

  psc_sync_edge #(.STAGES(STAGES)) i_sync_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .en_i    (msync_en_i),
    .pulse_o (msync)
  );

  psc_phase_cnt #(.DECIM(DECIM)) i_phase_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (msync),
    .phase_o   (phase_o),
    .valid_o   (word_valid_o)
  );

  psc_pattern_gen #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) i_pattern_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (test_en_i),
    .adv_i     (mod_bclk_en_i),
    .restart_i (msync & tsync_en_i),
    .ptr_o     (test_ptr_o),
    .bit_o     (test_bit_o)
  );

  assign msync_o = msync;
endmodule

// File: rtl/phase_sync_chk.sv
module phase_sync_chk #(
  parameter int unsigned DECIM   = 8,
  parameter int unsigned PAT_LEN = 16,
  localparam int unsigned CNT_W  = phase_sync_pkg::idx_w(DECIM),
  localparam int unsigned PTR_W  = phase_sync_pkg::idx_w(PAT_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msync_en_i,
  input logic             tsync_en_i,
  input logic             test_en_i,
  input logic             msync_o,
  input logic             word_valid_o,
  input logic [CNT_W-1:0] phase_o,
  input logic [PTR_W-1:0] test_ptr_o
);
  // R2
  msync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msync_o |=> !msync_o);

  // R4
  msync_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msync_en_i |=> !msync_o);

  // R5
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msync_o && phase_o != '0) |=> phase_o == $past(phase_o) - CNT_W'(1));

  // R5
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msync_o && word_valid_o) |=> phase_o == CNT_W'(DECIM - 1));

  // R6
  msync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msync_o |=> (phase_o == CNT_W'(DECIM - 1)) && !word_valid_o);

  // R9
  ptr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msync_o && tsync_en_i && test_en_i) |=> test_ptr_o == '0);

  // R11
  ptr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> test_ptr_o == '0);
endmodule

bind phase_sync_ctrl phase_sync_chk #(.DECIM(DECIM), .PAT_LEN(PAT_LEN)) i_phase_sync_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .msync_en_i   (msync_en_i),
  .tsync_en_i   (tsync_en_i),
  .test_en_i    (test_en_i),
  .msync_o      (msync_o),
  .word_valid_o (word_valid_o),
  .phase_o      (phase_o),
  .test_ptr_o   (test_ptr_o)
);

// File: tb/test_phase_sync_ctrl.sv
module test_phase_sync_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int L = 16;
  localparam logic [L-1:0] PAT = 16'hB4E1;
  localparam int CW = $clog2(D);
  localparam int PW = $clog2(L);

  localparam int K_MSYNC = 0;
  localparam int K_VALID = 1;
  localparam int K_PHASE = 2;
  localparam int K_PTR   = 3;
  localparam int K_BIT   = 4;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sync_i = 1'b0;
  logic          msync_en_i = 1'b0;
  logic          tsync_en_i = 1'b0;
  logic          test_en_i = 1'b0;
  logic          mod_bclk_en_i = 1'b0;
  logic          msync_o;
  logic          word_valid_o;
  logic [CW-1:0] phase_o;
  logic [PW-1:0] test_ptr_o;
  logic          test_bit_o;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  phase_sync_ctrl #(.DECIM(D), .PAT_LEN(L), .PATTERN(PAT)) i_phase_sync_ctrl (
    .clk_i, .rst_ni, .sync_i, .msync_en_i, .tsync_en_i, .test_en_i, .mod_bclk_en_i,
    .msync_o, .word_valid_o, .phase_o, .test_ptr_o, .test_bit_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int c, input int kind, input int val, input string req);
    exp_t e;
    e.cyc = c; e.kind = kind; e.val = val; e.req = req;
    sb_q.push_back(e);
  endtask

  function automatic int observe(input int kind);
    case (kind)
      K_MSYNC: return int'(msync_o);
      K_VALID: return int'(word_valid_o);
      K_PHASE: return int'(phase_o);
      K_PTR:   return int'(test_ptr_o);
      default: return int'(test_bit_o);
    endcase
  endfunction

  // monitor: compare every expected item due in this cycle
  always @(negedge clk_i) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].cyc == cyc) begin
        check($sformatf("%s kind=%0d", sb_q[i].req, sb_q[i].kind),
              observe(sb_q[i].kind), sb_q[i].val);
        sb_q.delete(i);
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk_i); while (int'(phase_o) != p);
  endtask

  function automatic int wrapd(input int v);
    return ((v % D) + D) % D;
  endfunction

  initial begin
    int c, c0, p, tstart, pc;
    ticks(3);
    // R1 reset state
    check("R1 msync", int'(msync_o), 0);
    check("R1 valid", int'(word_valid_o), 0);
    check("R1 phase", int'(phase_o), D - 1);
    check("R1 ptr", int'(test_ptr_o), 0);
    check("R1 bit", int'(test_bit_o), 0);
    rst_ni = 1'b1;
    msync_en_i = 1'b1;
    ticks(2);

    // R5 free-running cadence
    do @(negedge clk_i); while (!word_valid_o);
    c = cyc;
    expect_at(c + 1, K_PHASE, D - 1, "R5");
    expect_at(c + 2, K_PHASE, D - 2, "R5");
    expect_at(c + 1, K_VALID, 0, "R5");
    expect_at(c + D - 1, K_VALID, 0, "R5");
    expect_at(c + D, K_VALID, 1, "R5");
    expect_at(c + D, K_PHASE, 0, "R5");
    ticks(D + 2);

    // R2/R6 mid-phase sync, R3 level held
    wait_phase(6);
    sync_i = 1'b1; c = cyc;
    expect_at(c + 2, K_MSYNC, 0, "R2");
    expect_at(c + 3, K_MSYNC, 1, "R2");
    for (int k = 4; k <= 8; k++) expect_at(c + k, K_MSYNC, 0, "R3");
    expect_at(c + 4, K_PHASE, D - 1, "R6");
    expect_at(c + 6, K_VALID, 0, "R6");
    expect_at(c + 2 + D, K_VALID, 0, "R6");
    expect_at(c + 3 + D, K_VALID, 1, "R6");
    ticks(12);
    sync_i = 1'b0; c = cyc;
    for (int k = 2; k <= 5; k++) expect_at(c + k, K_MSYNC, 0, "R3");
    ticks(6);

    // R7 periodic sync landing on wrap
    wait_phase(3);
    c0 = cyc;
    for (int j = 0; j < 3; j++) begin
      while (cyc != c0 + j * D) @(negedge clk_i);
      sync_i = 1'b1;
      expect_at(c0 + j * D + 3, K_MSYNC, 1, "R7");
      expect_at(c0 + j * D + 3, K_VALID, 1, "R7");
      expect_at(c0 + j * D + 2, K_VALID, 0, "R7");
      expect_at(c0 + j * D + 4, K_PHASE, D - 1, "R7");
      ticks(4);
      sync_i = 1'b0;
    end
    expect_at(c0 + 3 * D + 3, K_VALID, 1, "R7");
    ticks(2 * D);

    // R4 gate off
    msync_en_i = 1'b0;
    ticks(2);
    p = int'(phase_o); c = cyc;
    sync_i = 1'b1;
    expect_at(c + 3, K_MSYNC, 0, "R4");
    expect_at(c + 4, K_MSYNC, 0, "R4");
    expect_at(c + 4, K_PHASE, wrapd(p - 4), "R4");
    expect_at(c + 6, K_PHASE, wrapd(p - 6), "R4");
    ticks(8);
    sync_i = 1'b0;
    ticks(4);
    msync_en_i = 1'b1;
    ticks(2);

    // R8 pointer advance, wrap, pattern bits
    test_en_i = 1'b1; mod_bclk_en_i = 1'b1; tstart = cyc;
    for (int k = 1; k <= L + 2; k++) begin
      expect_at(tstart + k, K_PTR, k % L, "R8");
      expect_at(tstart + k, K_BIT, int'(PAT[k % L]), "R8");
    end
    ticks(L + 3);
    mod_bclk_en_i = 1'b0; c = cyc;
    pc = (c - tstart) % L;
    for (int k = 1; k <= 3; k++) expect_at(c + k, K_PTR, pc, "R8");
    ticks(3);
    mod_bclk_en_i = 1'b1;
    tstart = cyc - pc;
    ticks(3);

    // R9 restart wins over advance
    tsync_en_i = 1'b1;
    ticks(1);
    sync_i = 1'b1; c = cyc;
    expect_at(c + 3, K_PTR, (c + 3 - tstart) % L, "R9");
    expect_at(c + 4, K_PTR, 0, "R9");
    expect_at(c + 4, K_BIT, int'(PAT[0]), "R9");
    expect_at(c + 5, K_PTR, 1, "R9");
    tstart = c + 4;
    ticks(6);
    sync_i = 1'b0;
    ticks(4);

    // R10 tsync off: pointer keeps advancing
    tsync_en_i = 1'b0;
    ticks(1);
    sync_i = 1'b1; c = cyc;
    expect_at(c + 3, K_MSYNC, 1, "R10");
    expect_at(c + 4, K_PTR, (c + 4 - tstart) % L, "R10");
    expect_at(c + 5, K_PTR, (c + 5 - tstart) % L, "R10");
    ticks(6);
    sync_i = 1'b0;
    ticks(4);

    // R11 test generator off
    test_en_i = 1'b0; c = cyc;
    expect_at(c + 1, K_PTR, 0, "R11");
    expect_at(c + 2, K_PTR, 0, "R11");
    expect_at(c + 1, K_BIT, 0, "R11");
    expect_at(c + 2, K_BIT, 0, "R11");
    ticks(4);

    while (sb_q.size() != 0) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog req=all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule